// File: doc/BRIEF.md
# Software-Managed Scratch Pad Memory

This block is a 4 KB on-chip scratch memory that a host core reaches through a fixed address window starting at 0x4000 and ending just below 0x5000. It has no cache machinery at all. There are no tags and no valid bits, so every access that falls inside the window hits. Software alone decides where data lives and when it is overwritten. For example, a layer's outputs may be written over that layer's own inputs. The 4 KB holds a few hundred bias values plus several thousand activations.

Storage is split into four byte-wide banks of 1024 entries each. The two lowest address bits pick the bank and the next ten bits pick the entry. On a write, only an 8-bit slice (bits 9 down to 2) of the 32-bit word is kept. On a read, the stored byte can be returned plain, zero-extended to 9 bits, or it can be widened into a 9-bit operand for a compute array by appending a constant 1 as the new least significant bit. A write whose address falls outside the window is passed unchanged to an external-memory write port in the same cycle.

Top module: `scratch_pad`

## Requirements
- R1: Only addresses 0x4000 through 0x4FFF are scratch-pad hits. A read outside the window produces no response, and a write outside the window changes no stored byte.
- R2: An in-window write stores bits [9:2] of the write data word.
- R3: A read with mode 0 returns the stored byte as {1'b0, byte} on the 9-bit read data.
- R4: A read with mode 1 returns {byte, 1'b1} on the 9-bit read data.
- R5: The read valid output rises exactly one cycle after an accepted in-window read, and at no other time.
- R6: An out-of-window write drives the external write valid in the same cycle, with the request address and data unchanged. In-window writes and all reads leave the external write valid low.
- R7: Address bits [1:0] select one of four banks and bits [11:2] select the entry, so all 4096 byte addresses hold independent values.
- R8: Without tags, a later in-window write to an address replaces its byte, and the next read returns the new value.
- R9: While reset is held, and right after it, the read valid and external write valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, one per cycle at most |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mode | input | 1 | Read format: 0 = plain byte, 1 = expanded operand |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data word |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 9 | Read response data |
| ext_wr_valid | output | 1 | Forwarded out-of-window write |
| ext_wr_addr | output | 32 | Forwarded write address |
| ext_wr_data | output | 32 | Forwarded write data |

## Verification
The assertions assume that at most one request arrives per cycle, and that no request is issued until the internal reset synchroniser has released, which takes two clock edges after rst_n rises. The bench waits several cycles after reset before its first request. It then presents each request for exactly one cycle, driven on the falling clock edge. Random addresses are kept to 32-bit values, weighted toward the window and its edges. This means both forwarded writes and in-window hits are exercised without overlapping requests.

// File: rtl/spm_pkg.sv
package spm_pkg;
  parameter int WORD_W   = 32;
  parameter int BYTE_W   = 8;
  parameter int SLICE_LO = 2;
  parameter int OPND_W   = BYTE_W + 1;

  function automatic logic [BYTE_W-1:0] pack_word(input logic [WORD_W-1:0] w);
    return w[SLICE_LO +: BYTE_W];
  endfunction

  function automatic logic [OPND_W-1:0] widen_byte(input logic [BYTE_W-1:0] b,
                                                   input logic as_operand);
    return as_operand ? {b, 1'b1} : {1'b0, b};
  endfunction
endpackage

// File: rtl/spm_decode.sv
module spm_decode #(
  parameter int ADDR_W   = 32,
  parameter int SEL_W    = 2,
  parameter int IDX_W    = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0000_4000
) (
  input  logic [ADDR_W-1:0]      addr,
  output logic                   in_win,
  output logic [(1<<SEL_W)-1:0]  bank_oh,
  output logic [SEL_W-1:0]       bank_sel,
  output logic [IDX_W-1:0]       entry
);
  localparam int SPAN_W = SEL_W + IDX_W;

  always_comb begin
    in_win   = (addr[ADDR_W-1:SPAN_W] == WIN_BASE[ADDR_W-1:SPAN_W]);
    bank_sel = addr[SEL_W-1:0];
    entry    = addr[SPAN_W-1:SEL_W];
    bank_oh  = '0;
    bank_oh[bank_sel] = in_win;
  end
endmodule

// File: rtl/spm_bank.sv
module spm_bank #(
  parameter int DEPTH = 1024,
  parameter int WID   = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [IW-1:0]  idx,
  input  logic [WID-1:0] wdata,
  output logic [WID-1:0] rdata
);
  logic [WID-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= cells[idx];
  end
endmodule

// File: rtl/scratch_pad.sv
module scratch_pad
  import spm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BANKS      = 4,
  parameter int BANK_DEPTH = 1024,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0000_4000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic                 req_mode,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rd_valid,
  output logic [OPND_W-1:0]    rd_data,
  output logic                 ext_wr_valid,
  output logic [ADDR_W-1:0]    ext_wr_addr,
  output logic [WORD_W-1:0]    ext_wr_data
);
  localparam int SEL_W = $clog2(BANKS);
  localparam int IDX_W = $clog2(BANK_DEPTH);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic              hit;
  logic [BANKS-1:0]  hit_oh;
  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  entry;

  spm_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr(req_addr), .in_win(hit), .bank_oh(hit_oh),
    .bank_sel(sel), .entry(entry)
  );

  logic [BYTE_W-1:0]             wr_byte;
  logic [BANKS-1:0][BYTE_W-1:0]  bank_q;
  logic                          acc_rd;

  assign wr_byte = pack_word(req_wdata);
  assign acc_rd  = req_valid && !req_we && hit && rst_int_n;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic b_wr, b_rd;
    assign b_wr = req_valid &&  req_we && hit_oh[b] && rst_int_n;
    assign b_rd = acc_rd && hit_oh[b];
    spm_bank #(.DEPTH(BANK_DEPTH), .WID(BYTE_W)) u_bank (
      .clk(clk), .wr_en(b_wr), .rd_en(b_rd), .idx(entry),
      .wdata(wr_byte), .rdata(bank_q[b])
    );
  end

  // response tracking: next-state and register processes
  logic             rv_q, rv_d;
  logic [SEL_W-1:0] rb_q, rb_d;
  logic             rm_q, rm_d;
  logic             cap_en;

  always_comb begin
    rv_d   = acc_rd;
    cap_en = acc_rd;
    rb_d   = sel;
    rm_d   = req_mode;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rv_q <= 1'b0;
    else            rv_q <= rv_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      rb_q <= rb_d;
      rm_q <= rm_d;
    end
  end

  assign rd_valid = rv_q;
  assign rd_data  = widen_byte(bank_q[rb_q], rm_q);

  // out-of-window writes go straight through
  assign ext_wr_valid = req_valid && req_we && !hit && rst_int_n;
  assign ext_wr_addr  = req_addr;
  assign ext_wr_data  = req_wdata;
endmodule

// File: rtl/scratch_pad_chk.sv
module scratch_pad_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_we,
  input logic        req_mode,
  input logic [31:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        rd_valid,
  input logic [8:0]  rd_data,
  input logic        ext_wr_valid,
  input logic [31:0] ext_wr_addr,
  input logic [31:0] ext_wr_data
);
  logic win;
  assign win = (req_addr[31:12] == 20'h00004);

  assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && win) |=> rd_valid);

  assert_no_stray_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_we && win));

  assert_fwd_exact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && !win) |->
      (ext_wr_valid && ext_wr_addr == req_addr && ext_wr_data == req_wdata));

  assert_no_fwd_on_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_valid |-> (req_valid && req_we && !win));

  assert_operand_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_mode)) |-> rd_data[0]);

  assert_plain_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !$past(req_mode)) |-> !rd_data[8]);
endmodule

bind scratch_pad scratch_pad_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
  .rd_valid(rd_valid), .rd_data(rd_data), .ext_wr_valid(ext_wr_valid),
  .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data)
);

// File: tb/scratch_pad_tb.sv
module scratch_pad_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we, req_mode;
  logic [31:0] req_addr, req_wdata;
  logic        rd_valid;
  logic [8:0]  rd_data;
  logic        ext_wr_valid;
  logic [31:0] ext_wr_addr, ext_wr_data;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [4096];

  always #4 clk = ~clk;

  scratch_pad u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ext_wr_valid(ext_wr_valid),
    .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data)
  );

  function automatic bit in_window(input logic [31:0] a);
    return a >= 32'h4000 && a < 32'h5000;
  endfunction

  function automatic logic [8:0] exp_read(input logic [7:0] b, input logic m);
    return m ? {b, 1'b1} : {1'b0, b};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access: driven at negedge, forwarding checked mid-cycle,
  // response checked at the following negedge
  task automatic access(input logic we, input logic [31:0] a,
                        input logic [31:0] d, input logic m, input bit chk_data);
    bit w;
    w = in_window(a);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mode = m;
    #1;
    if (we && !w) begin
      check("R6 fwd valid", ext_wr_valid, 1);
      check("R6 fwd addr", ext_wr_addr, a);
      check("R6 fwd data", ext_wr_data, d);
    end else begin
      check("R6 no fwd", ext_wr_valid, 0);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (we && w) model[a[11:0]] = d[9:2];
    if (!we) begin
      check(w ? "R5 rsp valid" : "R1 no rsp outside", rd_valid, w);
      if (w && chk_data)
        check(m ? "R4 operand read" : "R3 byte read", rd_data,
              exp_read(model[a[11:0]], m));
    end else begin
      check("R5 no rsp on write", rd_valid, 0);
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    rst_n = 1'b0; req_valid = 0; req_we = 0; req_mode = 0;
    req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    check("R9 rd_valid in reset", rd_valid, 0);
    check("R9 ext valid in reset", ext_wr_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 rd_valid after reset", rd_valid, 0);

    // fill whole window: distinct neighbours per bank (R7, R2)
    for (int i = 0; i < 4096; i++)
      access(1, 32'h4000 + i, {$urandom} , 0, 0);
    for (int i = 0; i < 16; i++)
      access(0, 32'h4000 + i * 251, 0, i[0], 1);

    // R2: only bits 9..2 kept
    access(1, 32'h4004, 32'hFFFF_FC03, 0, 0);
    access(0, 32'h4004, 0, 0, 1);
    check("R2 slice", rd_data, 9'h000);
    access(1, 32'h4005, 32'h0000_03FC, 0, 0);
    access(0, 32'h4005, 0, 0, 1);
    check("R2 slice ones", rd_data, 9'h0FF);
    access(0, 32'h4005, 0, 1, 1);
    check("R4 ones operand", rd_data, 9'h1FF);
    // R7: neighbours untouched
    access(0, 32'h4006, 0, 0, 1);
    access(0, 32'h4004, 0, 0, 1);

    // R1: window edges
    access(1, 32'h0000_4000, 32'h0000_0154, 0, 0);
    access(1, 32'h0000_4FFF, 32'h0000_02A8, 0, 0);
    access(1, 32'h0000_3FFF, 32'h0000_0000, 0, 0);
    access(1, 32'h0000_5000, 32'h0000_03FC, 0, 0);
    access(1, 32'h0001_4000, 32'h0000_03FC, 0, 0);
    access(0, 32'h0000_4000, 0, 0, 1);
    check("R1 base kept after alias write", rd_data, 9'h055);
    access(0, 32'h0000_4FFF, 0, 1, 1);
    check("R1 top operand", rd_data, 9'h155);
    access(0, 32'h0000_5000, 0, 0, 1);
    access(0, 32'h0000_3FFF, 0, 1, 1);

    // R8: overwrite replaces
    access(1, 32'h4ABC, 32'h0000_0010, 0, 0);
    access(1, 32'h4ABC, 32'h0000_0020, 0, 0);
    access(0, 32'h4ABC, 0, 0, 1);
    check("R8 overwrite", rd_data, 9'h008);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      a = ($urandom % 10 < 7) ? 32'h4000 + ($urandom % 4096) : $urandom;
      access($urandom % 2, a, $urandom, $urandom % 2, 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule